// File: doc/BRIEF.md
# UART Processor-Side Register Interface

This block sits between a processor bus and the serial engines of a UART. It decodes a chip select, a write strobe and a 2-bit address against a shared bidirectional 8-bit data bus. It holds the outgoing data byte and the control byte. It also keeps four status flags: transmit buffer empty, receive buffer full, overrun and framing error. The transmitter and receiver report events as single-cycle set pulses. The block clears flags as a side effect of bus accesses, so the processor never writes the status byte directly.

The control byte carries two interrupt enables and a 3-bit baud-rate select. The select goes straight to an external baud generator. The interrupt request combines each enable with the flag it guards. The serial shifters and the baud divider sit outside this block.

Top module: `uart_regif`

## Requirements
- R1: After synchronous reset the transmit-empty flag is 1, the receive-full, overrun and framing flags are 0, the control byte is 0x00, `baud_sel` is 0 and `irq` is 0.
- R2: A read cycle (`sel`=1, `we`=0) at address 0 drives `rx_byte` onto `bus` in that same cycle.
- R3: A write cycle at address 0 loads `tx_byte` from `bus` at the next clock edge and clears the transmit-empty flag.
- R4: A `tx_taken` pulse sets the transmit-empty flag. It wins over a same-cycle write at address 0.
- R5: An `rx_ready` pulse sets the receive-full flag. A read at address 0 clears it, but a same-cycle `rx_ready` pulse wins.
- R6: The status byte read at address 1 has bit 7 = transmit-empty, bit 6 = receive-full, bits 5:2 = 0, bit 1 = overrun and bit 0 = framing error. The overrun and framing flags are set by `rx_overrun` and `rx_framing`. They are cleared by the same address-0 read that clears receive-full, and a same-cycle set wins.
- R7: A write at address 1 changes no register or flag, and the block leaves `bus` undriven.
- R8: Addresses 2 and 3 both read and write the control byte. Its layout is bit 7 = transmit interrupt enable, bit 6 = receive interrupt enable, bits 5:3 reserved and read as 0, and bits 2:0 = `baud_sel`.
- R9: `irq` is 1 exactly when (transmit enable and transmit-empty) or (receive enable and receive-full) holds.
- R10: The block drives `bus` only while `sel`=1 and `we`=0. A cycle with `sel`=0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Chip select for a bus cycle |
| we | input | 1 | 1 = write cycle, 0 = read cycle |
| addr | input | 2 | Register address |
| bus | inout | 8 | Bidirectional data bus |
| rx_byte | input | 8 | Byte held by the receiver |
| tx_taken | input | 1 | Transmitter moved the byte to its shifter (set transmit-empty) |
| rx_ready | input | 1 | Receiver completed a byte (set receive-full) |
| rx_overrun | input | 1 | Receiver overrun event |
| rx_framing | input | 1 | Receiver framing-error event |
| tx_byte | output | 8 | Byte for the transmitter |
| baud_sel | output | 3 | Baud-rate select for the generator |
| tx_empty | output | 1 | Transmit-empty flag |
| rx_full | output | 1 | Receive-full flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with the package defaults: an 8-bit bus, a 3-bit baud select and four flags. These widths expose every status and control bit position directly. Among them are the reserved control bits, which must read back as zero after an all-ones write. The scenarios collide set pulses with clearing accesses in the same cycle to confirm that set wins. They also walk the interrupt through each enable and flag pairing. Undriven-bus cases are checked by having the bench drive its own pattern and reading that pattern back unchanged.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;

    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 2;
    localparam int BAUD_W  = 3;
    localparam int NFLAG   = 4;
    localparam int RSVD_W  = DATA_W - 2 - BAUD_W;
    localparam int ZERO_W  = DATA_W - NFLAG;

    // flag slots inside the flag vector
    localparam int FL_TXE  = 0;
    localparam int FL_RXF  = 1;
    localparam int FL_OVR  = 2;
    localparam int FL_FRM  = 3;
    localparam logic [NFLAG-1:0] FLAG_RST = 4'b0001;

    typedef struct packed {
        logic              tx_ie;
        logic              rx_ie;
        logic [RSVD_W-1:0] rsvd;
        logic [BAUD_W-1:0] baud;
    } ctrl_t;

    typedef struct packed {
        logic              txe;
        logic              rxf;
        logic [ZERO_W-1:0] zero;
        logic              ovr;
        logic              frm;
    } stat_t;

    typedef enum logic [2:0] {
        ACC_IDLE,
        ACC_RD_RX,
        ACC_WR_TX,
        ACC_RD_STAT,
        ACC_WR_NONE,
        ACC_RD_CTRL,
        ACC_WR_CTRL
    } acc_e;

    function automatic acc_e decode_acc(logic s, logic w, logic [ADDR_W-1:0] a);
        acc_e r;
        r = ACC_IDLE;
        if (s) begin
            if (a[1])            r = w ? ACC_WR_CTRL : ACC_RD_CTRL;
            else if (a[0])       r = w ? ACC_WR_NONE : ACC_RD_STAT;
            else                 r = w ? ACC_WR_TX   : ACC_RD_RX;
        end
        return r;
    endfunction

    function automatic stat_t pack_status(logic [NFLAG-1:0] f);
        stat_t s;
        s.txe  = f[FL_TXE];
        s.rxf  = f[FL_RXF];
        s.zero = '0;
        s.ovr  = f[FL_OVR];
        s.frm  = f[FL_FRM];
        return s;
    endfunction

    function automatic ctrl_t clean_ctrl(logic [DATA_W-1:0] d);
        ctrl_t c;
        c      = ctrl_t'(d);
        c.rsvd = '0;
        return c;
    endfunction

endpackage

// File: rtl/uart_regif_decode.sv
module uart_regif_decode
    import uart_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output acc_e              acc,
    output logic              ld_tx,
    output logic              ld_ctrl,
    output logic              rd_rx,
    output logic              drive_en
);

    always_comb begin
        acc      = decode_acc(sel, we, addr);
        ld_tx    = (acc == ACC_WR_TX);
        ld_ctrl  = (acc == ACC_WR_CTRL);
        rd_rx    = (acc == ACC_RD_RX);
        drive_en = (acc == ACC_RD_RX) || (acc == ACC_RD_STAT) || (acc == ACC_RD_CTRL);
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ld_tx, ld_ctrl, rd_rx})) else $error("strobe overlap"); // R10
    AST_DRIVE_ONLY_READ: assert property (@(posedge clk) disable iff (rst)
        drive_en |-> (sel && !we)) else $error("drive outside read"); // R10
    AST_NOSEL_QUIET: assert property (@(posedge clk) disable iff (rst)
        !sel |-> !(ld_tx || ld_ctrl || rd_rx)) else $error("strobe without select"); // R10

endmodule

// File: rtl/uart_regif_flags.sv
module uart_regif_flags
    import uart_regif_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NFLAG-1:0] set_ev,
    input  logic [NFLAG-1:0] clr_ev,
    output logic [NFLAG-1:0] flag_q
);

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)            flag_q[i] <= FLAG_RST[i];
            else if (set_ev[i]) flag_q[i] <= 1'b1;
            else if (clr_ev[i]) flag_q[i] <= 1'b0;
        end

        AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
            set_ev[i] |=> flag_q[i]) else $error("set lost"); // R4
        AST_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
            (clr_ev[i] && !set_ev[i]) |=> !flag_q[i]) else $error("clear lost"); // R5
        AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
            !(clr_ev[i] || set_ev[i]) |=> $stable(flag_q[i])) else $error("flag moved"); // R6
    end

endmodule

// File: rtl/uart_regif_regs.sv
module uart_regif_regs
    import uart_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_tx,
    input  logic              ld_ctrl,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] tx_q,
    output ctrl_t             ctrl_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q   <= '0;
            ctrl_q <= '0;
        end else begin
            if (ld_tx)   tx_q   <= din;
            if (ld_ctrl) ctrl_q <= clean_ctrl(din);
        end
    end

    AST_TX_LOAD: assert property (@(posedge clk) disable iff (rst)
        ld_tx |=> (tx_q == $past(din))) else $error("tx byte not loaded"); // R3
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ld_tx |=> $stable(tx_q)) else $error("tx byte moved"); // R7
    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ld_ctrl |=> $stable(ctrl_q)) else $error("control moved"); // R8
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.rsvd == '0) else $error("reserved bits set"); // R8

endmodule

// File: rtl/uart_regif.sv
module uart_regif
    import uart_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    inout  wire  [DATA_W-1:0] bus,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              tx_taken,
    input  logic              rx_ready,
    input  logic              rx_overrun,
    input  logic              rx_framing,
    output logic [DATA_W-1:0] tx_byte,
    output logic [BAUD_W-1:0] baud_sel,
    output logic              tx_empty,
    output logic              rx_full,
    output logic              irq
);

    acc_e              acc;
    logic              ld_tx, ld_ctrl, rd_rx, drive_en;
    logic [NFLAG-1:0]  set_ev, clr_ev, flag_q;
    ctrl_t             ctrl_q;
    stat_t             stat;
    logic [DATA_W-1:0] rdata;

    uart_regif_decode u_dec (
        .clk(clk), .rst(rst), .sel(sel), .we(we), .addr(addr),
        .acc(acc), .ld_tx(ld_tx), .ld_ctrl(ld_ctrl), .rd_rx(rd_rx),
        .drive_en(drive_en)
    );

    // event routing: the receive-data read clears every receive-side flag
    always_comb begin
        set_ev         = '0;
        clr_ev         = '0;
        set_ev[FL_TXE] = tx_taken;
        set_ev[FL_RXF] = rx_ready;
        set_ev[FL_OVR] = rx_overrun;
        set_ev[FL_FRM] = rx_framing;
        clr_ev[FL_TXE] = ld_tx;
        clr_ev[FL_RXF] = rd_rx;
        clr_ev[FL_OVR] = rd_rx;
        clr_ev[FL_FRM] = rd_rx;
    end

    uart_regif_flags u_flags (
        .clk(clk), .rst(rst), .set_ev(set_ev), .clr_ev(clr_ev), .flag_q(flag_q)
    );

    uart_regif_regs u_regs (
        .clk(clk), .rst(rst), .ld_tx(ld_tx), .ld_ctrl(ld_ctrl),
        .din(bus), .tx_q(tx_byte), .ctrl_q(ctrl_q)
    );

    always_comb begin
        stat = pack_status(flag_q);
        unique case (acc)
            ACC_RD_RX:   rdata = rx_byte;
            ACC_RD_STAT: rdata = stat;
            ACC_RD_CTRL: rdata = ctrl_q;
            default:     rdata = '0;
        endcase
    end

    assign bus      = drive_en ? rdata : 'z;
    assign baud_sel = ctrl_q.baud;
    assign tx_empty = flag_q[FL_TXE];
    assign rx_full  = flag_q[FL_RXF];
    assign irq      = (ctrl_q.tx_ie & flag_q[FL_TXE]) | (ctrl_q.rx_ie & flag_q[FL_RXF]);

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.tx_ie && !ctrl_q.rx_ie) |-> !irq) else $error("irq while masked"); // R9
    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
        irq |-> (tx_empty || rx_full)) else $error("irq without flag"); // R9
    AST_RESET_STATE: assert property (@(posedge clk)
        $past(rst) |-> (tx_empty && !rx_full && !irq && baud_sel == '0)) else $error("reset state"); // R1

endmodule

// File: tb/tb_uart_regif.sv
module tb_uart_regif;
    import uart_regif_pkg::*;

    localparam int K_BUS = 0, K_TX = 1, K_BAUD = 2, K_IRQ = 3, K_TXE = 4, K_RXF = 5;

    typedef struct {
        int          kind;
        logic [7:0]  exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel = 1'b0, we = 1'b0;
    logic [1:0]  addr = '0;
    logic        tb_oe = 1'b0;
    logic [7:0]  tb_val = '0;
    logic [7:0]  rx_byte = '0;
    logic        tx_taken = 1'b0, rx_ready = 1'b0, rx_overrun = 1'b0, rx_framing = 1'b0;
    wire  [7:0]  bus;
    logic [7:0]  tx_byte;
    logic [2:0]  baud_sel;
    logic        tx_empty, rx_full, irq;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    item_t sb[$];

    assign bus = tb_oe ? tb_val : 'z;

    always #5 clk = ~clk;

    uart_regif dut (
        .clk(clk), .rst(rst), .sel(sel), .we(we), .addr(addr), .bus(bus),
        .rx_byte(rx_byte), .tx_taken(tx_taken), .rx_ready(rx_ready),
        .rx_overrun(rx_overrun), .rx_framing(rx_framing), .tx_byte(tx_byte),
        .baud_sel(baud_sel), .tx_empty(tx_empty), .rx_full(rx_full), .irq(irq)
    );

    function automatic logic [7:0] observe(int k);
        case (k)
            K_BUS:   return bus;
            K_TX:    return tx_byte;
            K_BAUD:  return {5'b0, baud_sel};
            K_IRQ:   return {7'b0, irq};
            K_TXE:   return {7'b0, tx_empty};
            default: return {7'b0, rx_full};
        endcase
    endfunction

    // monitor: compares queued expectations mid-cycle, after the driver settles
    initial begin
        forever begin
            @(negedge clk);
            #3;
            while (sb.size() > 0) begin
                item_t it;
                logic [7:0] got;
                it  = sb.pop_front();
                got = observe(it.kind);
                n_chk++;
                if (got !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: got %02h expected %02h", it.tag, got, it.exp);
                end
            end
        end
    end

    task automatic expect_out(int k, logic [7:0] v, string tag);
        item_t it;
        it.kind = k; it.exp = v; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic bus_write(logic s, logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        sel = s; we = 1'b1; addr = a; tb_oe = 1'b1; tb_val = d;
        @(negedge clk);
        sel = 1'b0; we = 1'b0; tb_oe = 1'b0;
    endtask

    task automatic bus_read(logic [1:0] a, logic [7:0] e, string tag);
        @(negedge clk);
        sel = 1'b1; we = 1'b0; addr = a;
        expect_out(K_BUS, e, tag);
        @(negedge clk);
        sel = 1'b0;
    endtask

    task automatic pulse(logic t, logic r, logic o, logic f);
        @(negedge clk);
        tx_taken = t; rx_ready = r; rx_overrun = o; rx_framing = f;
        @(negedge clk);
        tx_taken = 0; rx_ready = 0; rx_overrun = 0; rx_framing = 0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got hang expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        expect_out(K_TXE, 8'h01, "R1 tx_empty");
        expect_out(K_RXF, 8'h00, "R1 rx_full");
        expect_out(K_IRQ, 8'h00, "R1 irq");
        expect_out(K_BAUD, 8'h00, "R1 baud");
        bus_read(2'd1, 8'h80, "R1 status");
        bus_read(2'd2, 8'h00, "R1 control");

        // R2 receive byte read
        rx_byte = 8'hC3;
        bus_read(2'd0, 8'hC3, "R2 rx read");
        rx_byte = 8'h3C;
        bus_read(2'd0, 8'h3C, "R2 rx read 2");

        // R3 transmit write
        bus_write(1'b1, 2'd0, 8'h5A);
        expect_out(K_TX, 8'h5A, "R3 tx byte");
        expect_out(K_TXE, 8'h00, "R3 tx_empty cleared");
        bus_read(2'd1, 8'h00, "R3 status");

        // R4 set and collision
        pulse(1, 0, 0, 0);
        expect_out(K_TXE, 8'h01, "R4 tx_empty set");
        @(negedge clk);
        sel = 1; we = 1; addr = 2'd0; tb_oe = 1; tb_val = 8'h11; tx_taken = 1;
        @(negedge clk);
        sel = 0; we = 0; tb_oe = 0; tx_taken = 0;
        expect_out(K_TXE, 8'h01, "R4 set wins");
        expect_out(K_TX, 8'h11, "R3 tx byte in collision");

        // R5 receive-full
        pulse(0, 1, 0, 0);
        expect_out(K_RXF, 8'h01, "R5 rx_full set");
        bus_read(2'd1, 8'hC0, "R6 status with rxf");
        bus_read(2'd0, 8'h3C, "R2 rx read clears");
        expect_out(K_RXF, 8'h00, "R5 read clears");
        @(negedge clk);
        sel = 1; we = 0; addr = 2'd0; rx_ready = 1;
        @(negedge clk);
        sel = 0; rx_ready = 0;
        expect_out(K_RXF, 8'h01, "R5 set wins");

        // R6 overrun / framing
        pulse(0, 0, 1, 0);
        pulse(0, 0, 0, 1);
        bus_read(2'd1, 8'hC3, "R6 status all");
        bus_read(2'd0, 8'h3C, "R6 clearing read");
        bus_read(2'd1, 8'h80, "R6 cleared");
        @(negedge clk);
        sel = 1; we = 0; addr = 2'd0; rx_framing = 1;
        @(negedge clk);
        sel = 0; rx_framing = 0;
        bus_read(2'd1, 8'h81, "R6 framing set wins");
        bus_read(2'd0, 8'h3C, "R6 clear framing");
        bus_read(2'd1, 8'h80, "R6 framing cleared");

        // R8 aliased control
        bus_write(1'b1, 2'd3, 8'hFD);
        bus_read(2'd2, 8'hC5, "R8 alias readback");
        bus_read(2'd3, 8'hC5, "R8 readback addr3");
        expect_out(K_BAUD, 8'h05, "R8 baud");

        // R9 interrupt pairing
        expect_out(K_IRQ, 8'h01, "R9 tx_ie with tx_empty");
        bus_write(1'b1, 2'd2, 8'h40);
        expect_out(K_IRQ, 8'h00, "R9 rx_ie no rxf");
        pulse(0, 1, 0, 0);
        expect_out(K_IRQ, 8'h01, "R9 rx_ie with rxf");
        bus_read(2'd0, 8'h3C, "R9 clearing read");
        expect_out(K_IRQ, 8'h00, "R9 rxf cleared");
        bus_write(1'b1, 2'd2, 8'h80);
        bus_write(1'b1, 2'd0, 8'h99);
        expect_out(K_IRQ, 8'h00, "R9 tx_empty cleared");
        pulse(1, 0, 0, 0);
        expect_out(K_IRQ, 8'h01, "R9 tx_taken raises");

        // R7 write to status address
        @(negedge clk);
        sel = 1; we = 1; addr = 2'd1; tb_oe = 1; tb_val = 8'h77;
        expect_out(K_BUS, 8'h77, "R7 bus not driven");
        @(negedge clk);
        sel = 0; we = 0; tb_oe = 0;
        bus_read(2'd2, 8'h80, "R7 control kept");
        bus_read(2'd1, 8'h80, "R7 status kept");
        expect_out(K_TX, 8'h99, "R7 tx byte kept");

        // R10 deselected cycles
        bus_write(1'b0, 2'd2, 8'h07);
        bus_read(2'd2, 8'h80, "R10 deselected write ignored");
        bus_write(1'b0, 2'd0, 8'h22);
        expect_out(K_TX, 8'h99, "R10 tx byte kept");
        @(negedge clk);
        sel = 0; we = 0; addr = 2'd0; tb_oe = 1; tb_val = 8'hA5;
        expect_out(K_BUS, 8'hA5, "R10 no drive when deselected");
        @(negedge clk);
        tb_oe = 0;

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule